// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Edge Capture

This block is a parallel I/O port of up to 32 pins that sits on a simple register bus with separate read and write strobes, a byte address, 32-bit write data and registered 32-bit read data. Each pin has an output value bit and a direction bit. The pad side is split into three signals per pin: output enable, output value and input level, so that tri-state pad cells stay outside the block.

Every input passes through a two-flop synchronizer. The block then detects edges on the synchronized level. One trigger type is fixed at build time: rising, falling, either edge, or level-high. In the edge modes, each detected edge sets a sticky capture bit. Software clears a capture bit by writing a 1 to it. The single interrupt line is high while any captured bit is also enabled in the interrupt mask. In level-high mode there is no capture. The interrupt then follows the data view of the pins, ANDed with the mask.

Top module: `gpio_edge_port`

## Requirements
- R1: A synchronous active-high reset clears direction, output value, mask and capture to zero. After reset, `pin_oe`, `pin_out` and `irq` are all 0.
- R2: Registers are selected by `bus_addr[3:2]`: 0 is data (byte 0x0), 1 is direction (0x4), 2 is interrupt mask (0x8) and 3 is edge capture (0xC). A read strobe at one clock edge places the word on `bus_rdata` at that same edge, so read data lags the strobe by one cycle.
- R3: Register bits at or above `NPINS` read as 0, and writes to them have no effect.
- R4: A direction bit of 1 makes the pin an output and a 0 makes it an input. `pin_oe` equals the direction register. `pin_out` equals the output value register.
- R5: A read of the data register returns the output value for output pins and the synchronized input level for input pins. A write to the data register updates the output value of every pin.
- R6: An input change is synchronized through two flops. In the edge modes, the capture bit is set at the third rising clock edge after the change, so `irq` rises at that edge when the pin is unmasked.
- R7: A capture bit stays set until a write to the capture register has a 1 in that bit position. Writing 0 leaves the bit unchanged.
- R8: In the edge modes, `irq` is high exactly while (capture AND mask) is nonzero. A mask bit of 1 enables the pin and 0 disables it.
- R9: The rising mode captures only 0→1 transitions, the falling mode captures only 1→0 transitions, and the any-edge mode captures both.
- R10: In level-high mode, `irq` is high while (data view AND mask) is nonzero. The capture register reads as 0 in this mode.
- R11: If a new edge on a pin arrives in the same cycle as a write-1-to-clear of that pin's capture bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Pad input levels (asynchronous) |
| pin_out | output | NPINS | Output value to the pads |
| pin_oe | output | NPINS | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
Two functions can fall in the same cycle: a freshly detected edge and a software write that clears the same capture bit. The bench provokes this by changing a pin and counting two clock edges of synchronizer delay. It then places the clearing write on the third edge, which is the edge at which the capture happens. The outcome is judged by reading the capture register afterwards: the bit must still be set. A plain clear issued later, with the pins steady, must then drop both the bit and the interrupt.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int BUS_W    = 32;
    localparam int MAX_PINS = 32;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_ANY   = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_e;

    // The register index is taken from the word-address bits of the bus.
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_MASK = 2'd2,
        SEL_CAP  = 2'd3
    } sel_e;

    typedef struct packed {
        logic             wr;
        logic             rd;
        sel_e             sel;
        logic [BUS_W-1:0] wdata;
    } bus_req_t;

    function automatic sel_e addr_to_sel(input logic [3:0] byte_addr);
        return sel_e'(byte_addr[3:2]);
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] prev_o
);
    logic [N-1:0] meta_q, lvl_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            lvl_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_i;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    assign lvl_o  = lvl_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/gpio_edge_cap.sv
module gpio_edge_cap
    import gpio_edge_pkg::*;
#(
    parameter int    N    = 32,
    parameter trig_e TRIG = TRIG_RISE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] prev_i,
    input  logic [N-1:0] view_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] cap_o,
    output logic         irq_o
);
    generate
        if (TRIG == TRIG_LEVEL) begin : g_level
            assign cap_o = '0;
            assign irq_o = |(view_i & mask_i);
        end else begin : g_edge
            logic [N-1:0] hit;
            logic [N-1:0] cap_q;

            if (TRIG == TRIG_RISE) begin : g_rise
                assign hit = lvl_i & ~prev_i;
            end else if (TRIG == TRIG_FALL) begin : g_fall
                assign hit = ~lvl_i & prev_i;
            end else begin : g_any
                assign hit = lvl_i ^ prev_i;
            end

            // A fresh edge is ORed in after the clear, so it wins a collision.
            always_ff @(posedge clk) begin
                if (rst) cap_q <= '0;
                else     cap_q <= (cap_q & ~clr_i) | hit;
            end

            assign cap_o = cap_q;
            assign irq_o = |(cap_q & mask_i);

            a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
                ((cap_q & ($past(cap_q) & ~$past(clr_i))) == ($past(cap_q) & ~$past(clr_i))))
                else $error("R7: capture bit lost without a clear");

            a_r11_edge_kept: assert property (@(posedge clk) disable iff (rst)
                ((cap_q & $past(hit)) == $past(hit)))
                else $error("R11: detected edge not captured");
        end
    endgenerate
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter int    NPINS = 32,
    parameter trig_e TRIG  = TRIG_RISE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [3:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic             irq
);
    localparam int N = (NPINS > MAX_PINS) ? MAX_PINS : NPINS;

    bus_req_t req;
    assign req = '{wr: bus_wr, rd: bus_rd, sel: addr_to_sel(bus_addr), wdata: bus_wdata};

    logic [N-1:0] dir_q, out_q, mask_q;
    logic [N-1:0] lvl, prev, view, cap, clr;
    logic [BUS_W-1:0] rdata_q, rd_word;

    gpio_pin_sync #(.N(N)) u_sync (
        .clk(clk), .rst(rst), .pin_i(pin_in[N-1:0]), .lvl_o(lvl), .prev_o(prev)
    );

    assign view = (dir_q & out_q) | (~dir_q & lvl);
    assign clr  = (req.wr && req.sel == SEL_CAP) ? req.wdata[N-1:0] : '0;

    gpio_edge_cap #(.N(N), .TRIG(TRIG)) u_cap (
        .clk(clk), .rst(rst), .lvl_i(lvl), .prev_i(prev), .view_i(view),
        .clr_i(clr), .mask_i(mask_q), .cap_o(cap), .irq_o(irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            out_q  <= '0;
            mask_q <= '0;
        end else if (req.wr) begin
            case (req.sel)
                SEL_DATA: out_q  <= req.wdata[N-1:0];
                SEL_DIR:  dir_q  <= req.wdata[N-1:0];
                SEL_MASK: mask_q <= req.wdata[N-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        rd_word = '0;
        case (req.sel)
            SEL_DATA: rd_word[N-1:0] = view;
            SEL_DIR:  rd_word[N-1:0] = dir_q;
            SEL_MASK: rd_word[N-1:0] = mask_q;
            default:  rd_word[N-1:0] = cap;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (req.rd) rdata_q <= rd_word;
    end

    assign bus_rdata = rdata_q;
    assign pin_out   = out_q;
    assign pin_oe    = dir_q;

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && pin_out == '0 && irq == 1'b0))
        else $error("R1: outputs not idle after reset");

    a_r5_out_hold: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr[3:2] == 2'd0) |=> $stable(pin_out))
        else $error("R5: output value changed without a data write");

    a_r8_irq_needs_mask: assert property (@(posedge clk) disable iff (rst)
        irq |-> (mask_q != '0))
        else $error("R8: interrupt raised with every pin masked");

    a_r4_dir_hold: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr[3:2] == 2'd1) |=> $stable(pin_oe))
        else $error("R4: direction changed without a direction write");
endmodule

// File: tb/gpio_edge_port_bench.sv
`timescale 1ns/1ps
module gpio_edge_port_bench;
    import gpio_edge_pkg::*;

    localparam int NP = 8;
    localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_PIN = 2'd2;
    localparam int NV = 19;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [NP-1:0] pins = '0;
    logic [31:0] rd_rise, rd_fall, rd_any, rd_lvl;
    logic [NP-1:0] out_rise, oe_rise, out_fall, oe_fall, out_any, oe_any, out_lvl, oe_lvl;
    logic irq_rise, irq_fall, irq_any, irq_lvl;
    int nvec = 0, nfail = 0;

    always #2.5 clk = ~clk;

    gpio_edge_port #(.NPINS(NP), .TRIG(TRIG_RISE)) u_gpio_edge_port (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_rise), .pin_in(pins),
        .pin_out(out_rise), .pin_oe(oe_rise), .irq(irq_rise));
    gpio_edge_port #(.NPINS(NP), .TRIG(TRIG_FALL)) u_fall (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_fall), .pin_in(pins),
        .pin_out(out_fall), .pin_oe(oe_fall), .irq(irq_fall));
    gpio_edge_port #(.NPINS(NP), .TRIG(TRIG_ANY)) u_any (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_any), .pin_in(pins),
        .pin_out(out_any), .pin_oe(oe_any), .irq(irq_any));
    gpio_edge_port #(.NPINS(NP), .TRIG(TRIG_LEVEL)) u_lvl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_lvl), .pin_in(pins),
        .pin_out(out_lvl), .pin_oe(oe_lvl), .irq(irq_lvl));

    // {req[3:0], kind[1:0], addr[3:0], data[31:0], expect[31:0]} for the rising-mode port
    localparam logic [73:0] VEC [NV] = '{
        {4'd1,  K_RD,  4'h0, 32'h0,        32'h0},          // R1 data after reset
        {4'd1,  K_RD,  4'h4, 32'h0,        32'h0},          // R1 direction after reset
        {4'd3,  K_WR,  4'h4, 32'hFFFFFFFF, 32'h0},
        {4'd3,  K_RD,  4'h4, 32'h0,        32'h000000FF},   // R3 upper bits dropped
        {4'd5,  K_WR,  4'h0, 32'h000000A5, 32'h0},
        {4'd5,  K_RD,  4'h0, 32'h0,        32'h000000A5},   // R5 outputs read back
        {4'd2,  K_WR,  4'h4, 32'h0000000F, 32'h0},
        {4'd2,  K_RD,  4'h4, 32'h0,        32'h0000000F},   // R2 direction offset
        {4'd6,  K_PIN, 4'h0, 32'h00000060, 32'h0},
        {4'd5,  K_RD,  4'h0, 32'h0,        32'h00000065},   // R5 mixed view
        {4'd9,  K_RD,  4'hC, 32'h0,        32'h00000060},   // R9 rising captured
        {4'd7,  K_WR,  4'hC, 32'h00000020, 32'h0},
        {4'd7,  K_RD,  4'hC, 32'h0,        32'h00000040},   // R7 write-1 clears
        {4'd7,  K_WR,  4'hC, 32'h00000000, 32'h0},
        {4'd7,  K_RD,  4'hC, 32'h0,        32'h00000040},   // R7 write-0 keeps
        {4'd9,  K_PIN, 4'h0, 32'h00000000, 32'h0},
        {4'd9,  K_RD,  4'hC, 32'h0,        32'h00000040},   // R9 falling ignored
        {4'd3,  K_WR,  4'h8, 32'hFFFFFFFF, 32'h0},
        {4'd3,  K_RD,  4'h8, 32'h0,        32'h000000FF}    // R3 mask width
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic drive_pins(input logic [NP-1:0] v);
        @(negedge clk);
        pins = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 oe", {24'd0, oe_rise}, 32'h0);
        check("R1 irq", {31'd0, irq_lvl}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][69:68])
                K_WR:  bus_write(VEC[i][67:64], VEC[i][63:32]);
                K_PIN: drive_pins(VEC[i][39:32]);
                default: begin
                    bus_read(VEC[i][67:64]);
                    check($sformatf("R%0d vector %0d", VEC[i][73:70], i), rd_rise, VEC[i][31:0]);
                end
            endcase
        end
        check("R4 oe", {24'd0, oe_rise}, 32'h0000000F);
        check("R4 out", {24'd0, out_rise}, 32'h000000A5);
        check("R8 irq held capture", {31'd0, irq_rise}, 32'h1);

        // Directed: all four trigger modes side by side
        @(negedge clk); rst = 1'b1; pins = '0;
        repeat (2) @(negedge clk); rst = 1'b0;
        check("R1 capture after reset", {31'd0, irq_rise}, 32'h0);
        bus_write(4'h8, 32'h000000FF);

        @(negedge clk); pins = 8'h01;
        repeat (2) @(negedge clk);
        check("R6 not yet captured", {31'd0, irq_rise}, 32'h0);
        @(negedge clk);
        check("R6 captured third edge", {31'd0, irq_rise}, 32'h1);
        check("R9 any on rise", {31'd0, irq_any}, 32'h1);
        check("R9 fall quiet on rise", {31'd0, irq_fall}, 32'h0);
        check("R10 level high", {31'd0, irq_lvl}, 32'h1);

        drive_pins(8'h00);
        check("R9 fall on fall", {31'd0, irq_fall}, 32'h1);
        check("R10 level low", {31'd0, irq_lvl}, 32'h0);
        bus_read(4'hC);
        check("R9 rise capture", rd_rise, 32'h01);
        check("R9 fall capture", rd_fall, 32'h01);
        check("R9 any capture", rd_any, 32'h01);
        check("R10 no capture", rd_lvl, 32'h0);

        // R11 collision: clear lands on the capturing edge
        @(negedge clk); pins = 8'h02;
        repeat (2) @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'hC; bus_wdata = 32'h02;
        @(negedge clk); bus_wr = 1'b0;
        bus_read(4'hC);
        check("R11 edge beats clear", rd_rise, 32'h03);
        check("R11 any edge beats clear", rd_any, 32'h03);
        bus_write(4'hC, 32'h000000FF);
        bus_read(4'hC);
        check("R7 full clear", rd_rise, 32'h0);
        check("R8 irq drops", {31'd0, irq_rise}, 32'h0);

        drive_pins(8'h06);
        check("R10 level on bit2", {31'd0, irq_lvl}, 32'h1);
        bus_write(4'h8, 32'h0);
        check("R10 masked level", {31'd0, irq_lvl}, 32'h0);
        check("R8 masked capture", {31'd0, irq_rise}, 32'h0);
        bus_write(4'h8, 32'h04);
        check("R8 unmask raises", {31'd0, irq_rise}, 32'h1);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule